// File: doc/BRIEF.md
# Staged-Expiration Watchdog Controller

This block watches one of up to sixteen external periodic timers and counts how often that timer fires. After a programmable number of timer firings it records one watchdog expiration and moves up one escalation stage. The first stages raise interrupts of increasing severity. The fourth stage raises a debug-reset request, and the fifth raises a power-on-reset request. Software keeps the system alive by re-issuing a start command before the count runs out. A start command always sends the escalation back to stage zero.

Software reaches the block through a small write bus with a combinational read-back of the configuration word. The block has three words: configuration at offset 0x0, command at offset 0x8 and unlock at offset 0xC. A stop command only takes effect right after the unlock word has been written with the key value. Setting the local-interrupt enable freezes the configuration until the block is reset.

Top module: `staged_wdt`

## Requirements
- R1: After reset the configuration word is zero. Reading offset 0x0 returns the configuration in bits [16:0] with zeros above. Reads at any other offset return zero.
- R2: Configuration bits [3:0] choose which input of `tmr_expire` is counted. Pulses on every other input have no effect.
- R3: Configuration bits [11:4] hold N, the number of selected-timer pulses per watchdog expiration. N = 0 is treated as 1.
- R4: Writing offset 0x8 with bit 0 set starts the watchdog. It clears the stage and the pulse count, so any active interrupt outputs drop.
- R5: Writing offset 0x8 with bit 1 set stops the watchdog and clears its stage, but only if the unlock word was armed. Without that, the stop is ignored.
- R6: Writing 0x0000C45A to offset 0xC arms the unlock. Writing any other value there disarms it. Any command write disarms it, whatever bits that write carries.
- R7: While the watchdog is running, three interrupt outputs follow the stage. `irq_local` is set at stage 1 or above when bit 12 is set. `fiq_local` is set at stage 2 or above when bit 13 is set. `irq_remote` is set at stage 3 or above when bit 14 is set.
- R8: On reaching stage 4, `dbg_rst_req` is set if bit 15 is set. It then stays high until the block is reset.
- R9: On reaching stage 5 (the fifth expiration after a start), `por_rst_req` is set if bit 16 is set. It then stays high until the block is reset.
- R10: Once bit 12 of the configuration is set, configuration writes are ignored until reset, and reads return the frozen value.
- R11: While the watchdog is stopped, timer pulses change neither the stage nor the outputs.
- R12: If one command write carries both bit 0 and bit 1, an armed stop wins over the start. If the unlock was not armed, the write acts as a start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 4 | Byte offset of the addressed word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| tmr_expire | input | 16 | One-cycle expiration pulses from the external timers |
| irq_local | output | 1 | Local interrupt, stage 1 |
| fiq_local | output | 1 | Local fast interrupt, stage 2 |
| irq_remote | output | 1 | Remote interrupt, stage 3 |
| dbg_rst_req | output | 1 | Sticky debug-reset request, stage 4 |
| por_rst_req | output | 1 | Sticky power-on-reset request, stage 5 |

## Verification
Some properties hold on every cycle, and the assertions check those. Both reset requests stay high once set. The configuration cannot change while the lock bit is held. Any command write leaves the unlock disarmed. A command write without an armed unlock never stops a running watchdog. The interrupt outputs appear only while running, and with the local enable set, the fast interrupt never appears without the local one.

Other behaviour only shows up in the bench's scenarios. These include the exact number of selected pulses needed per stage, the treatment of a zero period, and that other timer inputs are ignored. They also include the priority when one command carries both bits, and the full escalation from the first interrupt to the power-on-reset request.

// File: rtl/swdt_pkg.sv
package swdt_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int SRC_W  = 4;
  localparam int PER_W  = 8;
  localparam int CFG_W  = SRC_W + PER_W + 5;

  localparam logic [ADDR_W-1:0] OFS_CFG = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_CMD = 4'h8;
  localparam logic [ADDR_W-1:0] OFS_KEY = 4'hC;

  localparam logic [DATA_W-1:0] KEY_VALUE = 32'h0000_C45A;

  localparam int CMD_GO   = 0;
  localparam int CMD_HALT = 1;

  // Field order matches the decoded bit positions: src [3:0], period [11:4],
  // enables 12..16 from local interrupt up to power-on reset.
  typedef struct packed {
    logic             por_en;
    logic             dbg_en;
    logic             rem_en;
    logic             fiq_en;
    logic             loc_en;
    logic [PER_W-1:0] period;
    logic [SRC_W-1:0] src;
  } cfg_t;
endpackage

// File: rtl/swdt_regs.sv
module swdt_regs
  import swdt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output cfg_t              cfg,
  output logic              go_cmd,
  output logic              halt_cmd,
  output logic              key_armed
);
  cfg_t cfg_q, cfg_d;
  logic key_q, key_d;
  logic cfg_we, cmd_we, key_we;
  logic cfg_upd, key_upd;

  always_comb begin
    cfg_we  = wr_en && (addr == OFS_CFG);
    cmd_we  = wr_en && (addr == OFS_CMD);
    key_we  = wr_en && (addr == OFS_KEY);

    // local interrupt enable acts as the configuration lock
    cfg_upd = cfg_we && !cfg_q.loc_en;
    cfg_d   = cfg_t'(wdata[CFG_W-1:0]);

    key_upd = key_we || cmd_we;
    key_d   = key_we && (wdata == KEY_VALUE);

    halt_cmd = cmd_we && wdata[CMD_HALT] && key_q;
    go_cmd   = cmd_we && wdata[CMD_GO] && !halt_cmd;

    rdata = '0;
    if (addr == OFS_CFG) rdata[CFG_W-1:0] = cfg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_upd) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      key_q <= 1'b0;
    end else if (key_upd) begin
      key_q <= key_d;
    end
  end

  assign cfg       = cfg_q;
  assign key_armed = key_q;
endmodule

// File: rtl/swdt_tick.sv
module swdt_tick #(
  parameter int NUM_SRC = 16,
  parameter int SRC_W   = 4,
  parameter int PER_W   = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] expire_vec,
  input  logic [SRC_W-1:0]   src,
  input  logic [PER_W-1:0]   period,
  input  logic               run,
  input  logic               clear,
  output logic               wd_exp
);
  localparam int SPAN = 1 << SRC_W;

  logic [SPAN-1:0]  padded;
  logic             sel_pulse;
  logic [PER_W-1:0] limit;
  logic [PER_W:0]   nxt;
  logic             hit;
  logic             cnt_en;
  logic [PER_W-1:0] cnt_q, cnt_d;

  always_comb begin
    padded                = '0;
    padded[NUM_SRC-1:0]   = expire_vec;
    sel_pulse             = padded[src];
    limit  = (period == '0) ? PER_W'(1) : period;
    nxt    = {1'b0, cnt_q} + (PER_W+1)'(1);
    hit    = (nxt >= {1'b0, limit});
    wd_exp = run && sel_pulse && !clear && hit;
    cnt_en = clear || (run && sel_pulse);
    cnt_d  = (clear || hit) ? '0 : nxt[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/swdt_stage.sv
module swdt_stage #(
  parameter int STAGES = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic halt,
  input  logic wd_exp,
  input  logic loc_en,
  input  logic fiq_en,
  input  logic rem_en,
  input  logic dbg_en,
  input  logic por_en,
  output logic running,
  output logic irq_local,
  output logic fiq_local,
  output logic irq_remote,
  output logic dbg_req,
  output logic por_req
);
  localparam int STG_W = $clog2(STAGES + 1);
  localparam logic [STG_W-1:0] LV_LOC  = STG_W'(1);
  localparam logic [STG_W-1:0] LV_FIQ  = STG_W'(2);
  localparam logic [STG_W-1:0] LV_REM  = STG_W'(3);
  localparam logic [STG_W-1:0] LV_DBG  = STG_W'(STAGES - 1);
  localparam logic [STG_W-1:0] LV_TOP  = STG_W'(STAGES);

  logic             run_q, run_d, run_en;
  logic [STG_W-1:0] stg_q, stg_d;
  logic             stg_en;
  logic             dbg_q, dbg_set;
  logic             por_q, por_set;
  logic             adv;

  always_comb begin
    run_en = go || halt;
    run_d  = go;
    adv    = wd_exp && (stg_q != LV_TOP);
    stg_en = go || halt || adv;
    stg_d  = (go || halt) ? '0 : stg_q + STG_W'(1);
    dbg_set = adv && dbg_en && (stg_q + STG_W'(1) == LV_DBG);
    por_set = adv && por_en && (stg_q + STG_W'(1) == LV_TOP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
    end else if (run_en) begin
      run_q <= run_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_q <= '0;
    end else if (stg_en) begin
      stg_q <= stg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dbg_q <= 1'b0;
      por_q <= 1'b0;
    end else begin
      if (dbg_set) dbg_q <= 1'b1;
      if (por_set) por_q <= 1'b1;
    end
  end

  assign running    = run_q;
  assign irq_local  = run_q && loc_en && (stg_q >= LV_LOC);
  assign fiq_local  = run_q && fiq_en && (stg_q >= LV_FIQ);
  assign irq_remote = run_q && rem_en && (stg_q >= LV_REM);
  assign dbg_req    = dbg_q;
  assign por_req    = por_q;
endmodule

// File: rtl/staged_wdt.sv
module staged_wdt
  import swdt_pkg::*;
#(
  parameter int NUM_SRC = 16,
  parameter int STAGES  = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] tmr_expire,
  output logic               irq_local,
  output logic               fiq_local,
  output logic               irq_remote,
  output logic               dbg_rst_req,
  output logic               por_rst_req
);
  logic [1:0] rs_q;
  logic       rst_int_n;
  cfg_t       cfg;
  logic       go_cmd, halt_cmd, key_armed;
  logic       running, wd_exp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= '0;
    end else begin
      rs_q <= {rs_q[0], 1'b1};
    end
  end
  assign rst_int_n = rs_q[1];

  swdt_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (bus_wr),
    .addr     (bus_addr),
    .wdata    (bus_wdata),
    .rdata    (bus_rdata),
    .cfg      (cfg),
    .go_cmd   (go_cmd),
    .halt_cmd (halt_cmd),
    .key_armed(key_armed)
  );

  swdt_tick #(
    .NUM_SRC(NUM_SRC),
    .SRC_W  (SRC_W),
    .PER_W  (PER_W)
  ) u_tick (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .expire_vec(tmr_expire),
    .src       (cfg.src),
    .period    (cfg.period),
    .run       (running),
    .clear     (go_cmd || halt_cmd),
    .wd_exp    (wd_exp)
  );

  swdt_stage #(
    .STAGES(STAGES)
  ) u_stage (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .go        (go_cmd),
    .halt      (halt_cmd),
    .wd_exp    (wd_exp),
    .loc_en    (cfg.loc_en),
    .fiq_en    (cfg.fiq_en),
    .rem_en    (cfg.rem_en),
    .dbg_en    (cfg.dbg_en),
    .por_en    (cfg.por_en),
    .running   (running),
    .irq_local (irq_local),
    .fiq_local (fiq_local),
    .irq_remote(irq_remote),
    .dbg_req   (dbg_rst_req),
    .por_req   (por_rst_req)
  );
endmodule

// File: rtl/staged_wdt_checker.sv
module swdt_checker
  import swdt_pkg::*;
(
  input logic              clk,
  input logic              rst_int_n,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              key_armed,
  input logic              running,
  input logic [CFG_W-1:0]  cfg,
  input logic              irq_local,
  input logic              fiq_local,
  input logic              irq_remote,
  input logic              dbg_rst_req,
  input logic              por_rst_req
);
  logic unused_ok;
  assign unused_ok = ^bus_wdata;

  assert_por_sticky_R9: assert property (@(posedge clk) disable iff (!rst_int_n)
    por_rst_req |=> por_rst_req);

  assert_dbg_sticky_R8: assert property (@(posedge clk) disable iff (!rst_int_n)
    dbg_rst_req |=> dbg_rst_req);

  assert_cfg_frozen_R10: assert property (@(posedge clk) disable iff (!rst_int_n)
    cfg[12] |=> $stable(cfg));

  assert_key_consumed_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == OFS_CMD) |=> !key_armed);

  assert_halt_needs_key_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    (bus_wr && bus_addr == OFS_CMD && !key_armed && running) |=> running);

  assert_irq_needs_run_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (irq_local || fiq_local || irq_remote) |-> running);

  assert_irq_order_R7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (fiq_local && cfg[12]) |-> irq_local);
endmodule

bind staged_wdt swdt_checker u_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .bus_wdata  (bus_wdata),
  .key_armed  (key_armed),
  .running    (running),
  .cfg        (cfg),
  .irq_local  (irq_local),
  .fiq_local  (fiq_local),
  .irq_remote (irq_remote),
  .dbg_rst_req(dbg_rst_req),
  .por_rst_req(por_rst_req)
);

// File: tb/staged_wdt_tb_top.sv
`timescale 1ns/1ps
module staged_wdt_tb_top;
  logic        clk;
  logic        rst_n;
  logic        bus_wr;
  logic [3:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [15:0] tmr_expire;
  logic        irq_local, fiq_local, irq_remote, dbg_rst_req, por_rst_req;
  logic [4:0]  outs;

  typedef struct {
    string       tag;
    logic [31:0] rd;
    logic [4:0]  o;
  } exp_t;

  exp_t sb_q[$];
  exp_t item;
  int   vectors;
  int   miscompares;
  bit   done;

  staged_wdt dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .tmr_expire (tmr_expire),
    .irq_local  (irq_local),
    .fiq_local  (fiq_local),
    .irq_remote (irq_remote),
    .dbg_rst_req(dbg_rst_req),
    .por_rst_req(por_rst_req)
  );

  assign outs = {irq_local, fiq_local, irq_remote, dbg_rst_req, por_rst_req};

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // monitor: pops one expected item per falling edge and compares
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      item = sb_q.pop_front();
      vectors++;
      if (bus_rdata !== item.rd || outs !== item.o) begin
        miscompares++;
        $display("FAIL %s: rdata=%h out=%b expected rdata=%h out=%b",
                 item.tag, bus_rdata, outs, item.rd, item.o);
      end
    end
  end

  task automatic cycle();
    @(posedge clk);
    #1;
  endtask

  task automatic expect_out(input string tag, input logic [31:0] rd, input logic [4:0] o);
    sb_q.push_back('{tag, rd, o});
    @(negedge clk);
    #0.5;
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr    = 1'b1;
    bus_addr  = a;
    bus_wdata = d;
    cycle();
    bus_wr    = 1'b0;
    bus_addr  = 4'h0;
    bus_wdata = '0;
  endtask

  task automatic pulses(input int idx, input int n);
    for (int i = 0; i < n; i++) begin
      tmr_expire = 16'(1) << idx;
      cycle();
      tmr_expire = '0;
      cycle();
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      finish_run();
    end
  end

  initial begin
    vectors = 0; miscompares = 0; done = 1'b0;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = 4'h0; bus_wdata = '0; tmr_expire = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) cycle();

    expect_out("R1 reset state", 32'h0, 5'b00000);

    // src 3, period 2, fast + remote enables, unlocked
    wr(4'h0, 32'h0000_6023);
    expect_out("R1 cfg readback", 32'h0000_6023, 5'b00000);
    bus_addr = 4'h8;
    expect_out("R1 other offset reads zero", 32'h0, 5'b00000);
    bus_addr = 4'h0;

    pulses(3, 3);
    expect_out("R11 pulses before start ignored", 32'h6023, 5'b00000);

    wr(4'h8, 32'h1);
    pulses(5, 4);
    expect_out("R2 unselected source ignored", 32'h6023, 5'b00000);
    pulses(3, 2);
    expect_out("R3 stage1 after two pulses", 32'h6023, 5'b00000);
    pulses(3, 1);
    expect_out("R3 half period no advance", 32'h6023, 5'b00000);
    pulses(3, 1);
    expect_out("R7 fast interrupt at stage2", 32'h6023, 5'b01000);
    pulses(3, 2);
    expect_out("R7 remote interrupt at stage3", 32'h6023, 5'b01100);

    wr(4'h8, 32'h2);
    expect_out("R5 stop without key ignored", 32'h6023, 5'b01100);
    pulses(3, 2);
    expect_out("R8 debug reset disabled at stage4", 32'h6023, 5'b01100);

    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h0);
    wr(4'h8, 32'h2);
    expect_out("R6 key consumed by empty command", 32'h6023, 5'b01100);
    wr(4'hC, 32'h0000_1234);
    wr(4'h8, 32'h2);
    expect_out("R6 wrong key does not arm", 32'h6023, 5'b01100);
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h2);
    expect_out("R5 stop with key", 32'h6023, 5'b00000);
    pulses(3, 4);
    expect_out("R11 pulses while stopped ignored", 32'h6023, 5'b00000);

    // src 0, period 0, enables 13..16
    wr(4'h0, 32'h0001_E000);
    expect_out("R1 cfg rewrite readback", 32'h1E000, 5'b00000);
    wr(4'h8, 32'h1);
    pulses(0, 1);
    expect_out("R3 period zero stage1", 32'h1E000, 5'b00000);
    pulses(0, 1);
    expect_out("R3 period zero stage2", 32'h1E000, 5'b01000);
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h3);
    expect_out("R12 armed stop beats start", 32'h1E000, 5'b00000);
    wr(4'h8, 32'h3);
    pulses(0, 2);
    expect_out("R12 unarmed both bits start", 32'h1E000, 5'b01000);
    wr(4'h8, 32'h1);
    expect_out("R4 start restarts escalation", 32'h1E000, 5'b00000);
    pulses(0, 3);
    expect_out("R7 stage3 after restart", 32'h1E000, 5'b01100);
    pulses(0, 1);
    expect_out("R8 debug reset at stage4", 32'h1E000, 5'b01110);
    pulses(0, 1);
    expect_out("R9 power-on reset at stage5", 32'h1E000, 5'b01111);
    wr(4'hC, 32'h0000_C45A);
    wr(4'h8, 32'h2);
    expect_out("R9 R8 requests sticky after stop", 32'h1E000, 5'b00011);

    rst_n = 1'b0;
    cycle();
    rst_n = 1'b1;
    repeat (3) cycle();
    expect_out("R9 cleared only by block reset", 32'h0, 5'b00000);

    // src 1, period 1, local + por enables; locks configuration
    wr(4'h0, 32'h0001_1011);
    expect_out("R10 locking cfg readback", 32'h11011, 5'b00000);
    wr(4'h0, 32'h0);
    expect_out("R10 write ignored when locked", 32'h11011, 5'b00000);
    wr(4'h8, 32'h1);
    pulses(1, 1);
    expect_out("R7 local interrupt at stage1", 32'h11011, 5'b10000);
    pulses(0, 2);
    expect_out("R2 other source ignored", 32'h11011, 5'b10000);
    pulses(1, 3);
    expect_out("R8 no debug request when disabled", 32'h11011, 5'b10000);
    pulses(1, 1);
    expect_out("R9 fifth expiration reset request", 32'h11011, 5'b10001);

    done = 1'b1;
    finish_run();
  end
endmodule